// File: doc/BRIEF.md
# Serial Bit Clock Generator

This block makes the two timing strobes a serial channel needs: a sampling-clock enable and a bit-rate enable. Both are one-cycle pulses in the system clock domain. The channel logic uses them as clock enables, so nothing downstream runs on a derived clock.

The pulses come from one of two sources. In internal mode, every system clock cycle counts as a tick. The ticks go through a prescaler that divides by 10 or 30, and then through a power-of-two divider picked by a source/speed code; the result is the sampling rate. When the source/speed code is all ones, the sampling ticks are instead the rising edges of an external clock pin, which is first brought into the system clock domain by a two-flop synchroniser. In both modes a final ratio stage divides the sampling rate by 16 or 64 to give the bit rate. The ratio stage divides by 1 when the extended-mode bit is set.

Any change to any control input resets all divider counters to zero. A new setting therefore produces its first full period at a known time after the change.

Top module: `bclk_gen`

## Requirements
- R1: While reset is held, both enables stay low. After reset, with the source/speed input all ones and the external pin held still, no pulse appears.
- R2: With source/speed code n (0 to 6), the sampling enable pulses every P·2^n system cycles, where P is the prescale divisor. Each pulse lasts one cycle.
- R3: Prescale select 0 gives P = 10 and prescale select 1 gives P = 30.
- R4: With the extended-mode bit at 0, a bit enable is produced on every 16th sampling pulse when ratio select is 0, and on every 64th when ratio select is 1.
- R5: With the extended-mode bit at 1, every sampling pulse is also a bit pulse, whichever the ratio select value.
- R6: With source/speed all ones (3'b111), each rising edge of the external clock pin gives exactly one sampling pulse, after the two-flop synchroniser.
- R7: In external mode the prescale select has no effect on the pulse counts.
- R8: A change to any control input clears all counters. Counting cycles from the first clock edge that sees the new value, the first sampling pulse appears after that edge plus P·2^n further edges, and the first bit pulse after P·2^n·R edges (R is 1, 16 or 64).
- R9: The bit enable is never high unless the sampling enable is also high in the same cycle.
- R10: The sampling enable is never high on two consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ext_clk_i | input | 1 | External clock pin, asynchronous to clk |
| src_sel_i | input | SRC_W (3) | Source/speed code: all ones selects the external pin, n selects a 2^n divider |
| prescale_sel_i | input | 1 | 0 selects divide by 10, 1 selects divide by 30 (internal mode only) |
| ratio_sel_i | input | 1 | 0 selects sampling-to-bit ratio 16, 1 selects 64 |
| ext_mode_i | input | 1 | 1 forces the sampling-to-bit ratio to 1 |
| sample_en_o | output | 1 | One-cycle sampling-clock enable |
| bit_en_o | output | 1 | One-cycle bit-rate enable |

## Verification
The internal path is tested with several settings: the smallest divisor (10, code 0, ratio 16), prescale 30 with code 2 and a ratio of 1, the largest power-of-two code with ratio 64, and a mid-range code with prescale 30. For each setting the bench times the first and second sampling pulses and the first bit pulse, measured from the configuration change. The combined values separate a wrong prescale, a wrong shift amount and a wrong ratio. The external path receives 64 clean pin edges under each ratio setting. The sampling count shows that edges are neither lost nor doubled, and the bit count shows the ratio. A repeated run with prescale set to 30 shows that the prescaler stays out of the external path. One test changes the configuration in the middle of a count, so a design that does not clear its counters on a change would produce its first pulse too early.

// File: rtl/bclk_pkg.sv
package bclk_pkg;

    // Which tick stream drives the sampling stage
    typedef enum logic {
        SRC_SYS = 1'b0,
        SRC_PIN = 1'b1
    } src_kind_e;

    // Divisor from sampling clock to bit clock
    function automatic int unsigned ratio_div(input logic ratio_sel,
                                              input logic ext_mode,
                                              input int unsigned lo,
                                              input int unsigned hi);
        if (ext_mode) begin
            return 1;
        end
        return ratio_sel ? hi : lo;
    endfunction

    // Prescaler divisor for internal mode
    function automatic int unsigned pre_div(input logic pre_sel,
                                            input int unsigned lo,
                                            input int unsigned hi);
        return pre_sel ? hi : lo;
    endfunction

endpackage

// File: rtl/bclk_edge_sync.sv
module bclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_i,
    output logic rise_o
);
    // STAGES synchroniser flops plus one history flop for edge detect
    logic [STAGES:0] sync_d;
    logic [STAGES:0] sync_q;

    always_comb begin
        sync_d[0] = async_i;
        for (int i = 1; i <= STAGES; i++) begin
            sync_d[i] = sync_q[i-1];
        end
    end

    for (genvar g = 0; g <= STAGES; g++) begin : g_flop
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                sync_q[g] <= 1'b0;
            end else begin
                sync_q[g] <= sync_d[g];
            end
        end
    end

    assign rise_o = sync_q[STAGES-1] & ~sync_q[STAGES];

endmodule

// File: rtl/bclk_div_stage.sv
module bclk_div_stage #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr_i,
    input  logic             tick_i,
    input  logic [CNT_W-1:0] limit_i,
    output logic             pulse_o
);
    logic [CNT_W-1:0] cnt_d;
    logic [CNT_W-1:0] cnt_q;
    logic             wrap;

    always_comb begin
        wrap  = (cnt_q == limit_i);
        cnt_d = cnt_q;
        if (clr_i) begin
            cnt_d = '0;
        end else if (tick_i) begin
            cnt_d = wrap ? '0 : cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign pulse_o = tick_i & wrap & ~clr_i;

endmodule

// File: rtl/bclk_gen.sv
module bclk_gen
    import bclk_pkg::*;
#(
    parameter int SRC_W       = 3,
    parameter int PRE_LO      = 10,
    parameter int PRE_HI      = 30,
    parameter int RATIO_LO    = 16,
    parameter int RATIO_HI    = 64,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ext_clk_i,
    input  logic [SRC_W-1:0] src_sel_i,
    input  logic             prescale_sel_i,
    input  logic             ratio_sel_i,
    input  logic             ext_mode_i,
    output logic             sample_en_o,
    output logic             bit_en_o
);
    localparam int MAX_EXP = (1 << SRC_W) - 2;
    localparam int POW_W   = (MAX_EXP < 1) ? 1 : MAX_EXP;
    localparam int PRE_W   = $clog2(PRE_HI);
    localparam int RAT_W   = $clog2(RATIO_HI);

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             pre;
        logic             ratio;
        logic             ext;
    } cfg_t;

    typedef struct packed {
        cfg_t cfg;
        logic samp;
        logic bitp;
    } state_t;

    localparam cfg_t CFG_RST = '{src: '1, pre: 1'b0, ratio: 1'b0, ext: 1'b0};

    state_t     state_d;
    state_t     state_q;
    cfg_t       cfg_in;
    logic       clr;
    src_kind_e  kind;
    logic [PRE_W-1:0] pre_lim;
    logic [POW_W:0]   pow_full;
    logic [POW_W-1:0] pow_lim;
    logic [RAT_W-1:0] rat_lim;
    logic       pre_pulse;
    logic       pow_pulse;
    logic       pin_rise;
    logic       samp_tick;
    logic       rat_pulse;

    always_comb begin
        cfg_in.src   = src_sel_i;
        cfg_in.pre   = prescale_sel_i;
        cfg_in.ratio = ratio_sel_i;
        cfg_in.ext   = ext_mode_i;

        clr  = (cfg_in != state_q.cfg);
        kind = (cfg_in.src == '1) ? SRC_PIN : SRC_SYS;

        pre_lim  = PRE_W'(pre_div(cfg_in.pre, PRE_LO, PRE_HI) - 1);
        pow_full = ({{POW_W{1'b0}}, 1'b1} << cfg_in.src) - 1'b1;
        pow_lim  = pow_full[POW_W-1:0];
        rat_lim  = RAT_W'(ratio_div(cfg_in.ratio, cfg_in.ext, RATIO_LO, RATIO_HI) - 1);

        samp_tick = (kind == SRC_PIN) ? (pin_rise & ~clr) : pow_pulse;

        state_d      = state_q;
        state_d.cfg  = cfg_in;
        state_d.samp = samp_tick;
        state_d.bitp = rat_pulse;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '{cfg: CFG_RST, samp: 1'b0, bitp: 1'b0};
        end else begin
            state_q <= state_d;
        end
    end

    bclk_edge_sync #(
        .STAGES (SYNC_STAGES)
    ) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i (ext_clk_i),
        .rise_o  (pin_rise)
    );

    bclk_div_stage #(
        .CNT_W (PRE_W)
    ) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .tick_i  (kind == SRC_SYS),
        .limit_i (pre_lim),
        .pulse_o (pre_pulse)
    );

    bclk_div_stage #(
        .CNT_W (POW_W)
    ) u_pow (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .tick_i  (pre_pulse),
        .limit_i (pow_lim),
        .pulse_o (pow_pulse)
    );

    bclk_div_stage #(
        .CNT_W (RAT_W)
    ) u_rat (
        .clk     (clk),
        .rst_n   (rst_n),
        .clr_i   (clr),
        .tick_i  (samp_tick),
        .limit_i (rat_lim),
        .pulse_o (rat_pulse)
    );

    assign sample_en_o = state_q.samp;
    assign bit_en_o    = state_q.bitp;

endmodule

// File: rtl/bclk_gen_chk.sv
module bclk_gen_chk #(
    parameter int SRC_W  = 3,
    parameter int PRE_LO = 10,
    parameter int PRE_HI = 30
) (
    input logic             clk,
    input logic             rst_n,
    input logic [SRC_W-1:0] src_sel_i,
    input logic             prescale_sel_i,
    input logic             ratio_sel_i,
    input logic             ext_mode_i,
    input logic             sample_en_o,
    input logic             bit_en_o
);
    localparam int GW = 16;

    logic [SRC_W+2:0] ctl_now;
    logic [SRC_W+2:0] ctl_q;
    logic             chg;
    logic [GW-1:0]    gap_q;
    logic [GW-1:0]    period;

    assign ctl_now = {src_sel_i, prescale_sel_i, ratio_sel_i, ext_mode_i};
    assign chg     = (ctl_now != ctl_q);
    assign period  = GW'(prescale_sel_i ? PRE_HI : PRE_LO) << src_sel_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctl_q <= {{SRC_W{1'b1}}, 3'b000};
            gap_q <= '0;
        end else begin
            ctl_q <= ctl_now;
            if (chg) begin
                gap_q <= '0;
            end else if (sample_en_o) begin
                gap_q <= GW'(1);
            end else if (gap_q != '1) begin
                gap_q <= gap_q + 1'b1;
            end
        end
    end

    // R1
    always @(posedge clk) begin
        if (!rst_n) begin
            reset_quiet_chk: assert (!sample_en_o && !bit_en_o);
        end
    end

    // R2
    int_period_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_en_o && !chg && (src_sel_i != '1)) |-> (gap_q == period));

    // R8
    restart_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        chg |=> !sample_en_o);

    // R9
    bit_in_sample_chk: assert property (@(posedge clk) disable iff (!rst_n)
        bit_en_o |-> sample_en_o);

    // R10
    single_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        sample_en_o |=> !sample_en_o);

endmodule

bind bclk_gen bclk_gen_chk #(
    .SRC_W  (SRC_W),
    .PRE_LO (PRE_LO),
    .PRE_HI (PRE_HI)
) u_chk (
    .clk            (clk),
    .rst_n          (rst_n),
    .src_sel_i      (src_sel_i),
    .prescale_sel_i (prescale_sel_i),
    .ratio_sel_i    (ratio_sel_i),
    .ext_mode_i     (ext_mode_i),
    .sample_en_o    (sample_en_o),
    .bit_en_o       (bit_en_o)
);

// File: tb/sim_bclk_gen.sv
`timescale 1ns/1ps
module sim_bclk_gen;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ext_clk = 1'b0;
    logic [2:0] src_sel = 3'b111;
    logic       pre_sel = 1'b0;
    logic       rat_sel = 1'b0;
    logic       ext_mode = 1'b0;
    logic       sample_en;
    logic       bit_en;

    int checks = 0;
    int fails  = 0;

    always #4 clk = ~clk;

    bclk_gen u0 (
        .clk            (clk),
        .rst_n          (rst_n),
        .ext_clk_i      (ext_clk),
        .src_sel_i      (src_sel),
        .prescale_sel_i (pre_sel),
        .ratio_sel_i    (rat_sel),
        .ext_mode_i     (ext_mode),
        .sample_en_o    (sample_en),
        .bit_en_o       (bit_en)
    );

    task automatic chk(input string req, input string what, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic test_reset();
        int pulses = 0;
        @(negedge clk);
        chk("R1", "sample during reset", int'(sample_en), 0);
        chk("R1", "bit during reset", int'(bit_en), 0);
        rst_n = 1'b1;
        for (int c = 0; c < 50; c++) begin
            @(negedge clk);
            if (sample_en || bit_en) pulses++;
        end
        chk("R1", "pulses after reset, pin idle", pulses, 0);
    endtask

    // Drive a new internal setting and time the first pulses from the change
    task automatic run_int(input logic [2:0] n, input logic pre, input logic rat,
                           input logic xm, input int exp_s, input int exp_b,
                           input string req);
        int first_s = -1;
        int second_s = -1;
        int first_b = -1;
        int orphan = 0;
        @(negedge clk);
        src_sel = n; pre_sel = pre; rat_sel = rat; ext_mode = xm;
        @(posedge clk);
        for (int k = 1; k <= exp_b + exp_s + 2; k++) begin
            @(posedge clk);
            @(negedge clk);
            if (bit_en && !sample_en) orphan++;
            if (sample_en) begin
                if (first_s < 0) first_s = k;
                else if (second_s < 0) second_s = k;
            end
            if (bit_en && first_b < 0) first_b = k;
        end
        chk(req, "first sample edge", first_s, exp_s);
        chk(req, "second sample edge", second_s, 2 * exp_s);
        chk(req, "first bit edge", first_b, exp_b);
        chk("R9", "bit without sample", orphan, 0);
    endtask

    // External source: feed 64 clean pin edges and count pulses
    task automatic run_ext(input logic pre, input logic rat, input logic xm,
                           input int exp_b, input string req);
        int ns = 0;
        int nb = 0;
        @(negedge clk);
        ext_clk = 1'b0;
        src_sel = 3'b111; pre_sel = pre; rat_sel = rat; ext_mode = xm;
        repeat (10) @(negedge clk);
        for (int c = 0; c < 64 * 8 + 20; c++) begin
            @(negedge clk);
            if (sample_en) ns++;
            if (bit_en) nb++;
            ext_clk = (c < 64 * 8) && ((c % 8) < 4);
        end
        chk("R6", "sample pulses per 64 pin edges", ns, 64);
        chk(req, "bit pulses per 64 pin edges", nb, exp_b);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        test_reset();
        // R2 R3 R4: smallest divisor, ratio 16
        run_int(3'd0, 1'b0, 1'b0, 1'b0, 10, 160, "R2");
        // R3 R5: prescale 30, code 2, ratio bypass
        run_int(3'd2, 1'b1, 1'b1, 1'b1, 120, 120, "R5");
        // R4: largest code, ratio 64
        run_int(3'd6, 1'b0, 1'b1, 1'b0, 640, 40960, "R4");
        // R3: prescale 30, code 3, ratio 16
        run_int(3'd3, 1'b1, 1'b0, 1'b0, 240, 3840, "R3");
        // R8: stop mid-count, then change only the prescale select
        @(negedge clk);
        src_sel = 3'd1; pre_sel = 1'b0; rat_sel = 1'b0; ext_mode = 1'b0;
        repeat (13) @(negedge clk);
        run_int(3'd1, 1'b1, 1'b0, 1'b0, 60, 960, "R8");
        // R6 R4 R5 R7: external source
        run_ext(1'b0, 1'b0, 1'b0, 4, "R4");
        run_ext(1'b0, 1'b1, 1'b0, 1, "R4");
        run_ext(1'b0, 1'b0, 1'b1, 64, "R5");
        run_ext(1'b1, 1'b0, 1'b0, 4, "R7");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

endmodule